// File: doc/BRIEF.md
# Quad-Lane Shared-Write RAM

This block is a small distributed memory of four lanes (A, B, C, D). Each lane holds 32 locations of 2 bits. Every lane has its own read port with its own 5-bit address. The data of a read port follows its address combinationally, with no clock involved. A single clocked write port takes an 8-bit word and stores one 2-bit slice of it in each lane, all at the same location. The write location is taken from lane D's read address, so lane D always reads the location that is being written, while lanes A to C read wherever their own addresses point.

Each lane starts from a 64-bit initial-content parameter, two bits per location, and is all zeros when that parameter is left unset. A build option chooses whether writes take effect on the rising or the falling clock edge. The block suits register files and small lookup tables where one writer must feed several independent combinational readers. The write and read ports are plain control pins with no handshake: a write is accepted on every active edge at which the enable is high, and the block never applies back-pressure.

Top module: `qlram_quad`

## Requirements
- R1: Each lane has 32 locations. Each read address (`addr_a`, `addr_b`, `addr_c`, `addr_d`) is 5 bits wide, and each read output (`rd_a` to `rd_d`) is 2 bits wide. Every location 0 to 31 can be reached.
- R2: Reads are combinational. Each `rd_x` shows the contents at `addr_x` within the same time step, with no clock edge needed.
- R3: A write happens only at an active clock edge where `wr_en` is 1. When `wr_en` is 0 at that edge, no lane's contents change.
- R4: `addr_d` is the write location for all four lanes. One write updates location `addr_d` in lanes A, B, C and D together.
- R5: The slices of a write go to the lanes as follows: lane A stores `wr_data[1:0]`, lane B stores `wr_data[3:2]`, lane C stores `wr_data[5:4]` and lane D stores `wr_data[7:6]`.
- R6: Before any write, location z of a lane holds bits [2z+1:2z] of that lane's initial parameter (`INIT_A` to `INIT_D`). Each parameter defaults to zero, which makes every location of that lane 0.
- R7: With `WR_ON_FALL` = 0, writes take effect at the rising edge of `clk`. With `WR_ON_FALL` = 1, they take effect at the falling edge. The opposite edge never writes.
- R8: A read of the location being written returns the old contents up to the active edge and the new contents right after it.
- R9: A write leaves unchanged the output of every lane whose read address points at a different location and did not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock. The active edge is chosen by `WR_ON_FALL`. |
| wr_en | input | 1 | Write enable, sampled at the active edge |
| wr_data | input | 8 | Write word: one 2-bit slice per lane, with lane A in the low bits |
| addr_a | input | 5 | Read address of lane A |
| addr_b | input | 5 | Read address of lane B |
| addr_c | input | 5 | Read address of lane C |
| addr_d | input | 5 | Read address of lane D, also the write address of all lanes |
| rd_a | output | 2 | Lane A read data |
| rd_b | output | 2 | Lane B read data |
| rd_c | output | 2 | Lane C read data |
| rd_d | output | 2 | Lane D read data |

## Verification
The bench builds two copies of the block and drives them with the same stimulus. The first copy writes on the rising edge and has a distinct non-zero initial word in every lane, so a swapped slice, a wrong initial bit order or a wrong write lane shows up at once. The second copy writes on the falling edge and leaves every initial parameter at its default, which covers the all-zero start. Sampling halfway between the two clock edges catches one copy already showing the new data while the other still shows the old, and this is what tests the edge option and the old-before, new-after rule.

// File: rtl/qlram_pkg.sv
package qlram_pkg;
  // Number of lanes; the port set (A..D) fixes it at four.
  localparam int unsigned QL_LANES   = 4;
  // Lane whose read address also steers every write.
  localparam int unsigned QL_WR_LANE = 3;
endpackage

// File: rtl/qlram_wr_fanout.sv
module qlram_wr_fanout #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 2
) (
  input  logic                         wr_en,
  input  logic [LANES*LANE_W-1:0]      wr_data,
  output logic [LANES-1:0]             lane_we,
  output logic [LANES-1:0][LANE_W-1:0] lane_wd
);
  // Slice k of the write word belongs to lane k; every lane shares the enable.
  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign lane_we[g] = wr_en;
    assign lane_wd[g] = wr_data[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/qlram_lane.sv
module qlram_lane #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 2,
  parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT = '0,
  parameter bit WR_ON_FALL = 1'b0
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH  = 2**ADDR_W;
  localparam int INIT_W = DATA_W*DEPTH;

  typedef logic [DATA_W-1:0] mem_t [DEPTH];

  // Location z starts from bits [DATA_W*z +: DATA_W] of the initial word.
  function automatic mem_t unpack_init(input logic [INIT_W-1:0] v);
    mem_t m;
    for (int z = 0; z < DEPTH; z++) m[z] = v[z*DATA_W +: DATA_W];
    return m;
  endfunction

  mem_t mem = unpack_init(INIT);

  if (WR_ON_FALL) begin : g_fall_wr
    always_ff @(negedge clk) begin
      if (we) mem[wa] <= wd;
    end
  end else begin : g_rise_wr
    always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
    end
  end

  // Asynchronous read path.
  assign rd = mem[ra];
endmodule

// File: rtl/qlram_quad.sv
module qlram_quad
  import qlram_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LANE_W = 2,
  parameter logic [LANE_W*(2**ADDR_W)-1:0] INIT_A = '0,
  parameter logic [LANE_W*(2**ADDR_W)-1:0] INIT_B = '0,
  parameter logic [LANE_W*(2**ADDR_W)-1:0] INIT_C = '0,
  parameter logic [LANE_W*(2**ADDR_W)-1:0] INIT_D = '0,
  parameter bit WR_ON_FALL = 1'b0
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [QL_LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]          addr_a,
  input  logic [ADDR_W-1:0]          addr_b,
  input  logic [ADDR_W-1:0]          addr_c,
  input  logic [ADDR_W-1:0]          addr_d,
  output logic [LANE_W-1:0]          rd_a,
  output logic [LANE_W-1:0]          rd_b,
  output logic [LANE_W-1:0]          rd_c,
  output logic [LANE_W-1:0]          rd_d
);
  localparam int unsigned INIT_W = LANE_W*(2**ADDR_W);
  localparam logic [QL_LANES-1:0][INIT_W-1:0] INIT_SET = {INIT_D, INIT_C, INIT_B, INIT_A};

  logic [QL_LANES-1:0][ADDR_W-1:0] lane_ra;
  logic [QL_LANES-1:0][LANE_W-1:0] lane_rd;
  logic [QL_LANES-1:0]             lane_we;
  logic [QL_LANES-1:0][LANE_W-1:0] lane_wd;

  assign lane_ra = {addr_d, addr_c, addr_b, addr_a};
  assign {rd_d, rd_c, rd_b, rd_a} = lane_rd;

  qlram_wr_fanout #(
    .LANES (QL_LANES),
    .LANE_W(LANE_W)
  ) u_fanout (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .lane_we(lane_we),
    .lane_wd(lane_wd)
  );

  for (genvar g = 0; g < QL_LANES; g++) begin : g_lane
    qlram_lane #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (LANE_W),
      .INIT      (INIT_SET[g]),
      .WR_ON_FALL(WR_ON_FALL)
    ) u_lane (
      .clk(clk),
      .we (lane_we[g]),
      .wa (lane_ra[QL_WR_LANE]),
      .wd (lane_wd[g]),
      .ra (lane_ra[g]),
      .rd (lane_rd[g])
    );
  end
endmodule

// File: rtl/qlram_quad_chk.sv
module qlram_quad_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LANE_W = 2,
  parameter bit WR_ON_FALL = 1'b0
) (
  input logic                clk,
  input logic                wr_en,
  input logic [4*LANE_W-1:0] wr_data,
  input logic [ADDR_W-1:0]   addr_a,
  input logic [ADDR_W-1:0]   addr_b,
  input logic [ADDR_W-1:0]   addr_c,
  input logic [ADDR_W-1:0]   addr_d,
  input logic [LANE_W-1:0]   rd_a,
  input logic [LANE_W-1:0]   rd_b,
  input logic [LANE_W-1:0]   rd_c,
  input logic [LANE_W-1:0]   rd_d
);
  logic                    ck;
  logic [1:0]              arm = 2'b00;
  logic [3:0][ADDR_W-1:0]  ra;
  logic [3:0][LANE_W-1:0]  rd;

  assign ck = WR_ON_FALL ? ~clk : clk;
  assign ra = {addr_d, addr_c, addr_b, addr_a};
  assign rd = {rd_d, rd_c, rd_b, rd_a};

  // Two active edges must pass before any $past is trusted.
  always_ff @(posedge ck) arm <= {arm[0], 1'b1};

  for (genvar g = 0; g < 4; g++) begin : g_chk
    AST_WRITE_LANDS: assert property (@(posedge ck) disable iff (!arm[1])
      ($past(wr_en) && ra[g] == $past(addr_d)) |-> (rd[g] == $past(wr_data[g*LANE_W +: LANE_W])))
      else $error("lane %0d misses written slice", g); // R5
    AST_NO_WRITE_HOLDS: assert property (@(posedge ck) disable iff (!arm[1])
      (!$past(wr_en) && $stable(ra[g])) |-> $stable(rd[g]))
      else $error("lane %0d changed without write", g); // R3
    AST_OTHER_LOC_KEPT: assert property (@(posedge ck) disable iff (!arm[1])
      ($past(wr_en) && ra[g] != $past(addr_d) && $stable(ra[g])) |-> $stable(rd[g]))
      else $error("lane %0d disturbed by unrelated write", g); // R9
  end

  AST_SHARED_ADDR: assert property (@(posedge ck) disable iff (!arm[1])
    ($past(wr_en) && $stable(addr_d)) |-> (rd_d == $past(wr_data[4*LANE_W-1 -: LANE_W])))
    else $error("lane D not written at its own address"); // R4
endmodule

bind qlram_quad qlram_quad_chk #(
  .ADDR_W    (ADDR_W),
  .LANE_W    (LANE_W),
  .WR_ON_FALL(WR_ON_FALL)
) u_qlram_chk (
  .clk    (clk),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .addr_a (addr_a),
  .addr_b (addr_b),
  .addr_c (addr_c),
  .addr_d (addr_d),
  .rd_a   (rd_a),
  .rd_b   (rd_b),
  .rd_c   (rd_c),
  .rd_d   (rd_d)
);

// File: tb/test_qlram_quad.sv
module test_qlram_quad;
  localparam int CLK_P = 10;
  localparam logic [63:0] IA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] IB = 64'hA5A5_5A5A_F0F0_0F0F;
  localparam logic [63:0] IC = 64'hDEAD_BEEF_CAFE_F00D;
  localparam logic [63:0] ID = 64'h1357_9BDF_2468_ACE0;

  logic       clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] addr [4] = '{default: '0};
  logic [1:0] rr [4];
  logic [1:0] rf [4];

  always #(CLK_P/2) clk = ~clk;

  qlram_quad #(.INIT_A(IA), .INIT_B(IB), .INIT_C(IC), .INIT_D(ID), .WR_ON_FALL(1'b0)) i_qlram_quad (
    .clk(clk), .wr_en(wr_en), .wr_data(wr_data),
    .addr_a(addr[0]), .addr_b(addr[1]), .addr_c(addr[2]), .addr_d(addr[3]),
    .rd_a(rr[0]), .rd_b(rr[1]), .rd_c(rr[2]), .rd_d(rr[3]));

  qlram_quad #(.WR_ON_FALL(1'b1)) i_qlram_quad_fall (
    .clk(clk), .wr_en(wr_en), .wr_data(wr_data),
    .addr_a(addr[0]), .addr_b(addr[1]), .addr_c(addr[2]), .addr_d(addr[3]),
    .rd_a(rf[0]), .rd_b(rf[1]), .rd_c(rf[2]), .rd_d(rf[3]));

  typedef struct { bit fall; int lane; logic [1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event  sb_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [1:0] ref_r [4][32];
  logic [1:0] ref_f [4][32];

  function automatic logic [1:0] actual(bit fall, int lane);
    return fall ? rf[lane] : rr[lane];
  endfunction

  // Driver side: queue the expected read of every lane of the chosen copies.
  task automatic expect_lanes(string tag, bit do_r, bit do_f);
    for (int k = 0; k < 4; k++) begin
      if (do_r) sb_q.push_back('{1'b0, k, ref_r[k][addr[k]], tag});
      if (do_f) sb_q.push_back('{1'b1, k, ref_f[k][addr[k]], tag});
    end
    -> sb_ev;
    wait (sb_q.size() == 0);
  endtask

  // Monitor: pop and compare against the live outputs.
  initial begin
    item_t it;
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (actual(it.fall, it.lane) !== it.exp) begin
          n_fail++;
          $display("FAIL %s lane %0d (%s copy): actual %b expected %b",
                   it.tag, it.lane, it.fall ? "falling" : "rising",
                   actual(it.fall, it.lane), it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] wa;
    logic [7:0] wd;
    bit         we;
    // R6: reference contents from the initial words, two bits per location.
    for (int z = 0; z < 32; z++) begin
      ref_r[0][z] = IA[2*z +: 2];
      ref_r[1][z] = IB[2*z +: 2];
      ref_r[2][z] = IC[2*z +: 2];
      ref_r[3][z] = ID[2*z +: 2];
      for (int k = 0; k < 4; k++) ref_f[k][z] = 2'b00;
    end
    // R1, R2, R6: sweep all locations with wr_en low, one time unit apart.
    for (int a = 0; a < 32; a++) begin
      for (int k = 0; k < 4; k++) addr[k] = 5'((a + 7*k) % 32);
      #1;
      expect_lanes("R1/R2/R6", 1'b1, 1'b1);
    end
    @(posedge clk);
    #2;
    for (int n = 0; n < 400; n++) begin
      wa = 5'($urandom_range(31));
      wd = 8'($urandom_range(255));
      we = ($urandom_range(3) != 0);
      addr[3] = wa;
      for (int k = 0; k < 3; k++)
        addr[k] = ($urandom_range(3) == 0) ? wa : 5'($urandom_range(31));
      wr_data = wd;
      wr_en   = we;
      #1;
      expect_lanes("R2/R8", 1'b1, 1'b1);       // old contents before the edge
      #4;                                      // falling edge has passed
      if (we) for (int k = 0; k < 4; k++) ref_f[k][wa] = wd[2*k +: 2];
      expect_lanes("R7", 1'b1, 1'b1);          // falling copy new, rising copy old
      #4;                                      // rising edge has passed
      if (we) for (int k = 0; k < 4; k++) ref_r[k][wa] = wd[2*k +: 2];
      expect_lanes(we ? "R4/R5/R8/R9" : "R3", 1'b1, 1'b1);
      #1;
    end
    wr_en = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule